// File: doc/BRIEF.md
# MDIO PHY Auto-Poll Link Monitor

This block is a self-running management master for a clause 22 MDIO bus. It derives the management clock from the system clock, issues read frames to every PHY address from 0 to 31 in turn, and after each full pass it rests for a programmable number of idle management clock cycles before it starts again. Every frame reads register 1, the basic status register. A PHY that answers is marked in an alive bitmap, and bit 2 of its status word, the link flag, is copied into a link bitmap.

Software names one PHY address to watch. Each time the scan reads that address, the block compares the link state it got back with the state it holds. When the two differ, it updates the held state and raises a sticky event flag. The flag stays set until software clears it, and it drives an interrupt line when the interrupt enable is high. Software reads these bitmaps and flags directly and never has to wait on a slow serial transaction of its own.

Top module: `mdio_link_monitor`

## Requirements
- R1: `mdc` is low in reset and toggles every `mdc_div`+1 system clock cycles, so its period is 2*(`mdc_div`+1) clocks.
- R2: Each read frame drives, MSB first, 32 ones, start bits 0 then 1, opcode 1 then 0, the 5-bit PHY address and register address 00001. It then releases the line (`mdio_oe` low) for 18 bit times: two turnaround bits and 16 data bits. Driven values change only on a falling edge of `mdc`.
- R3: Frames address PHYs 0,1,...,31 and then wrap to 0. Within a pass each frame starts on the bit right after the previous one ends, so 18 released bit times lie between frames.
- R4: After the frame to address 31, the line stays released for `gap_len` more `mdc` cycles before the preamble to address 0 starts. With `gap_len` = 0 no idle cycles are added.
- R5: Bit n of `alive_map` holds 1 when the PHY at address n drove `mdio_i` low at the rising edge of `mdc` in the second turnaround bit of its latest frame, and 0 otherwise.
- R6: Bit n of `link_map` equals the alive bit of address n ANDed with bit 2 (data bit sampled 14th, counting data bit 15 as 1st) of the status word that address returned last.
- R7: `sel_link` (0 after reset) takes the value alive AND status bit 2 from each completed read of the address on `sel_phy`. It changes at no other time.
- R8: `link_evt` is set when a read of the selected address changes `sel_link`. It stays set until `evt_clr` is high, and no event is raised when the value is unchanged. A new event in the same cycle as a clear wins.
- R9: `irq` is high exactly when `link_evt` and `irq_en` are both high.
- R10: During reset `mdio_oe`, `mdc`, both bitmaps, `sel_link`, `link_evt` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_div | input | DIV_W | Half period of `mdc` minus one, in clocks |
| gap_len | input | GAP_W | Idle `mdc` cycles after each pass |
| sel_phy | input | 5 | PHY address whose link is tracked |
| irq_en | input | 1 | Interrupt enable |
| evt_clr | input | 1 | Clears the link-change event |
| mdio_i | input | 1 | Sampled MDIO line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| alive_map | output | 32 | Responding PHY addresses |
| link_map | output | 32 | Link flag of each responding PHY |
| sel_link | output | 1 | Held link state of the selected PHY |
| link_evt | output | 1 | Sticky link-change event |
| irq | output | 1 | Interrupt request |

## Verification
A PHY model on the bench decodes every frame, checks the preamble length, opcode, register and address order, and answers from per-address present and link masks. The status word has all other bits set for odd addresses and cleared for even ones, so a capture from the wrong bit shows up. The masks are swept through all-present, none-present, alternating and irregular patterns. Each pattern is checked in the bitmaps after full passes, which separates missing responders from link-down responders. The selected PHY is then toggled with the interrupt enable off and on, and moved to an absent address, to check event stickiness, clearing and gating. The clock divider and the idle gap are changed at run time, including a zero gap, and the bench measures the `mdc` period and the released runs between frames against the configured values.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;

  localparam int PHY_AW = 5;
  localparam int N_PHY  = 1 << PHY_AW;
  localparam int POS_W  = 6;

  localparam logic [POS_W-1:0]  LAST_POS  = 6'd63;
  localparam logic [POS_W-1:0]  POS_TA2   = 6'd47;
  localparam logic [POS_W-1:0]  POS_LINK  = 6'd61;
  localparam logic [PHY_AW-1:0] LAST_ADDR = 5'd31;
  localparam logic [4:0]        STAT_REG  = 5'd1;

  typedef enum logic {ST_GAP, ST_FRAME} seq_st_e;

  // returns {drive_enable, drive_value} for one bit slot of a read frame
  function automatic logic [1:0] frame_drive(input logic [POS_W-1:0] pos,
                                             input logic [PHY_AW-1:0] phy);
    logic [1:0] r;
    logic [2:0] idx;
    r   = 2'b00;
    idx = 3'd0;
    if (pos < 6'd32)       r = 2'b11;
    else if (pos == 6'd32) r = 2'b10;
    else if (pos == 6'd33) r = 2'b11;
    else if (pos == 6'd34) r = 2'b11;
    else if (pos == 6'd35) r = 2'b10;
    else if (pos < 6'd41) begin
      idx = 3'(6'd40 - pos);
      r   = {1'b1, phy[idx]};
    end else if (pos < 6'd46) begin
      idx = 3'(6'd45 - pos);
      r   = {1'b1, STAT_REG[idx]};
    end
    return r;
  endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             hit;

  always_comb begin
    hit      = (cnt_q >= div);
    cnt_d    = hit ? '0 : cnt_q + DIV_W'(1);
    mdc_d    = hit ? ~mdc_q : mdc_q;
    rise_stb = hit & ~mdc_q;
    fall_stb = hit &  mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;

  // R1: a rise strobe is followed by a high clock, a fall strobe by a low one
  assert_mdc_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
  assert_mdc_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc);

endmodule

// File: rtl/mdio_read_seq.sv
module mdio_read_seq
  import mdio_mon_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic [GAP_W-1:0]  gap_len,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              res_vld,
  output logic [PHY_AW-1:0] res_addr,
  output logic              res_alive,
  output logic              res_link
);

  seq_st_e           st_q, st_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [PHY_AW-1:0] addr_q, addr_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              alive_q, alive_d;
  logic              link_q, link_d;
  logic [1:0]        drv;

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    addr_d  = addr_q;
    gap_d   = gap_q;
    alive_d = alive_q;
    link_d  = link_q;
    if (fall_stb) begin
      unique case (st_q)
        ST_GAP: begin
          if (gap_q >= gap_len) begin
            st_d  = ST_FRAME;
            pos_d = '0;
          end else begin
            gap_d = gap_q + GAP_W'(1);
          end
        end
        ST_FRAME: begin
          if (pos_q == LAST_POS) begin
            pos_d = '0;
            if (addr_q == LAST_ADDR) begin
              addr_d = '0;
              if (gap_len != '0) begin
                st_d  = ST_GAP;
                gap_d = GAP_W'(1);
              end
            end else begin
              addr_d = addr_q + 5'd1;
            end
          end else begin
            pos_d = pos_q + 6'd1;
          end
        end
        default: ;
      endcase
    end
    if (rise_stb && (st_q == ST_FRAME)) begin
      if (pos_q == POS_TA2)  alive_d = ~mdio_i;
      if (pos_q == POS_LINK) link_d  = mdio_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_GAP;
      pos_q   <= '0;
      addr_q  <= '0;
      gap_q   <= '0;
      alive_q <= 1'b0;
      link_q  <= 1'b0;
    end else if (rise_stb || fall_stb) begin
      st_q    <= st_d;
      pos_q   <= pos_d;
      addr_q  <= addr_d;
      gap_q   <= gap_d;
      alive_q <= alive_d;
      link_q  <= link_d;
    end
  end

  always_comb begin
    drv       = (st_q == ST_FRAME) ? frame_drive(pos_q, addr_q) : 2'b00;
    mdio_oe   = drv[1];
    mdio_o    = drv[0];
    res_vld   = rise_stb && (st_q == ST_FRAME) && (pos_q == LAST_POS);
    res_addr  = addr_q;
    res_alive = alive_q;
    res_link  = link_q;
  end

  // R2: the driver switches only at falling edges of the management clock
  assert_oe_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $past(fall_stb));
  assert_o_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $past(fall_stb));
  // R3: address only ever advances by one (wrapping)
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> (addr_q == $past(addr_q) + 5'd1));

endmodule

// File: rtl/mdio_link_track.sv
module mdio_link_track
  import mdio_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld,
  input  logic [PHY_AW-1:0] res_addr,
  input  logic              res_alive,
  input  logic              res_link,
  input  logic [PHY_AW-1:0] sel_phy,
  input  logic              irq_en,
  input  logic              evt_clr,
  output logic [N_PHY-1:0]  alive_map,
  output logic [N_PHY-1:0]  link_map,
  output logic              sel_link,
  output logic              link_evt,
  output logic              irq
);

  logic [N_PHY-1:0] hit;
  logic [N_PHY-1:0] alive_q, alive_d;
  logic [N_PHY-1:0] lmap_q, lmap_d;
  logic             sel_q, sel_d;
  logic             evt_q, evt_d;
  logic             new_link, sel_hit, sel_chg;

  for (genvar i = 0; i < N_PHY; i++) begin : g_hit
    assign hit[i] = res_vld && (res_addr == PHY_AW'(i));
  end

  always_comb begin
    new_link = res_alive & res_link;
    alive_d  = (alive_q & ~hit) | (hit & {N_PHY{res_alive}});
    lmap_d   = (lmap_q  & ~hit) | (hit & {N_PHY{new_link}});
    sel_hit  = res_vld && (res_addr == sel_phy);
    sel_chg  = sel_hit && (new_link != sel_q);
    sel_d    = sel_hit ? new_link : sel_q;
    evt_d    = sel_chg | (evt_q & ~evt_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= '0;
      lmap_q  <= '0;
      sel_q   <= 1'b0;
    end else if (res_vld) begin
      alive_q <= alive_d;
      lmap_q  <= lmap_d;
      sel_q   <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign alive_map = alive_q;
  assign link_map  = lmap_q;
  assign sel_link  = sel_q;
  assign link_evt  = evt_q;
  assign irq       = evt_q & irq_en;

  // R7: held link of the selected PHY moves only on a completed read
  assert_sel_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(res_vld));
  // R8: event sticks until cleared
  assert_evt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q && !evt_clr) |=> evt_q);
  // R8: event rises only from a read of the selected address
  assert_evt_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> $past(res_vld && (res_addr == sel_phy)));

endmodule

// File: rtl/mdio_link_monitor.sv
module mdio_link_monitor
  import mdio_mon_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mdc_div,
  input  logic [GAP_W-1:0] gap_len,
  input  logic [4:0]       sel_phy,
  input  logic             irq_en,
  input  logic             evt_clr,
  input  logic             mdio_i,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [31:0]      alive_map,
  output logic [31:0]      link_map,
  output logic             sel_link,
  output logic             link_evt,
  output logic             irq
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              rise_stb, fall_stb;
  logic              res_vld, res_alive, res_link;
  logic [PHY_AW-1:0] res_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mdio_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .div      (mdc_div),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_read_seq #(.GAP_W(GAP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .gap_len   (gap_len),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .res_vld   (res_vld),
    .res_addr  (res_addr),
    .res_alive (res_alive),
    .res_link  (res_link)
  );

  mdio_link_track u_trk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .res_vld   (res_vld),
    .res_addr  (res_addr),
    .res_alive (res_alive),
    .res_link  (res_link),
    .sel_phy   (sel_phy),
    .irq_en    (irq_en),
    .evt_clr   (evt_clr),
    .alive_map (alive_map),
    .link_map  (link_map),
    .sel_link  (sel_link),
    .link_evt  (link_evt),
    .irq       (irq)
  );

endmodule

// File: tb/tb_mdio_link_monitor.sv
module tb_mdio_link_monitor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mdc_div;
  logic [7:0]  gap_len;
  logic [4:0]  sel_phy;
  logic        irq_en, evt_clr;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe;
  logic [31:0] alive_map, link_map;
  logic        sel_link, link_evt, irq;

  always #10 clk = ~clk;

  mdio_link_monitor dut (
    .clk(clk), .rst_n(rst_n), .mdc_div(mdc_div), .gap_len(gap_len),
    .sel_phy(sel_phy), .irq_en(irq_en), .evt_clr(evt_clr), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .alive_map(alive_map),
    .link_map(link_map), .sel_link(sel_link), .link_evt(link_evt), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  logic [31:0] present, linkup;
  bit   frame_chk_en = 0, gap_chk_en = 0, per_chk_en = 0;
  int   ones = 0, hst = 0, hcnt = 0, run = 0, pend_run = 0;
  int   hdr_cnt = 0, exp_phy = 0, resp = 0;
  bit   resp_arm = 0;
  logic [11:0] hdr;
  logic [15:0] rd_data;
  time  last_rise = 0;

  always @(posedge mdc) begin
    if (per_chk_en && last_rise != 0)
      chk(($time - last_rise) == 40 * (mdc_div + 1), "R1 mdc period",
          32'($time - last_rise), 32'(40 * (mdc_div + 1)));
    last_rise = $time;
    if (mdio_oe) begin
      if (run > 0) begin pend_run = run; run = 0; end
      case (hst)
        0: if (mdio_o) ones++;
           else begin
             if (frame_chk_en && ones > 0)
               chk(ones == 32, "R2 preamble length", 32'(ones), 32);
             hst = (ones >= 32) ? 1 : 0;
             ones = 0;
           end
        1: begin hst = mdio_o ? 2 : 0; hcnt = 0; end
        default: begin
          hdr = {hdr[10:0], mdio_o};
          hcnt++;
          if (hcnt == 12) begin
            if (frame_chk_en) begin
              chk(hdr[11:10] == 2'b10, "R2 opcode", 32'(hdr[11:10]), 2);
              chk(hdr[4:0] == 5'd1, "R2 register address", 32'(hdr[4:0]), 1);
              chk(int'(hdr[9:5]) == exp_phy, "R3 address order", 32'(hdr[9:5]), 32'(exp_phy));
            end
            if (gap_chk_en && hdr_cnt > 0)
              chk(pend_run == ((hdr[9:5] == 5'd0) ? 18 + int'(gap_len) : 18),
                  "R4 released run", 32'(pend_run),
                  32'((hdr[9:5] == 5'd0) ? 18 + int'(gap_len) : 18));
            exp_phy = (int'(hdr[9:5]) + 1) % 32;
            rd_data = hdr[5] ? 16'hFFFB : 16'h0000;
            rd_data[2] = linkup[hdr[9:5]];
            resp_arm = present[hdr[9:5]];
            resp = 0;
            hdr_cnt++;
            hst = 0;
          end
        end
      endcase
    end else begin
      run++;
      ones = 0;
      hst = 0;
    end
  end

  always @(negedge mdc) begin
    if (resp_arm) begin
      resp++;
      if (resp == 2)                      mdio_i = 1'b0;
      else if (resp >= 3 && resp <= 18)   mdio_i = rd_data[18 - resp];
      else                                mdio_i = 1'b1;
      if (resp == 19) begin resp_arm = 0; resp = 0; end
    end else begin
      mdio_i = 1'b1;
    end
  end

  task automatic wait_passes(input int n);
    int target;
    target = hdr_cnt + 32 * n + 1;
    while (hdr_cnt < target) @(negedge clk);
  endtask

  logic exp_sel;
  bit   exp_evt;

  task automatic check_maps(input string tag);
    logic ns;
    chk(alive_map == present, {"R5 alive map ", tag}, alive_map, present);
    chk(link_map == (present & linkup), {"R6 link map ", tag}, link_map, present & linkup);
    ns = present[sel_phy] & linkup[sel_phy];
    if (ns != exp_sel) exp_evt = 1;
    exp_sel = ns;
    chk(sel_link == exp_sel, {"R7 sel link ", tag}, 32'(sel_link), 32'(exp_sel));
    chk(link_evt == exp_evt, {"R8 event ", tag}, 32'(link_evt), 32'(exp_evt));
    chk(irq == (exp_evt & irq_en), {"R9 irq ", tag}, 32'(irq), 32'(exp_evt & irq_en));
  endtask

  task automatic clear_evt;
    @(negedge clk) evt_clr = 1'b1;
    @(negedge clk) evt_clr = 1'b0;
    exp_evt = 0;
    chk(link_evt == 1'b0, "R8 cleared", 32'(link_evt), 0);
    chk(irq == 1'b0, "R9 irq after clear", 32'(irq), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats_p [4];
    logic [31:0] pats_l [4];
    rst_n = 1'b0; mdc_div = 8'd0; gap_len = 8'd3; sel_phy = 5'd5;
    irq_en = 1'b1; evt_clr = 1'b0;
    present = 32'h5A3C_96E1; linkup = 32'h0F0F_3311;
    exp_sel = 1'b0; exp_evt = 0;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(mdc == 1'b0, "R10 mdc", 32'(mdc), 0);
    chk(mdio_oe == 1'b0, "R10 mdio_oe", 32'(mdio_oe), 0);
    chk(alive_map == 32'h0, "R10 alive", alive_map, 0);
    chk(link_map == 32'h0, "R10 link", link_map, 0);
    chk({sel_link, link_evt, irq} == 3'b000, "R10 flags", 32'({sel_link, link_evt, irq}), 0);
    rst_n = 1'b1;
    frame_chk_en = 1; gap_chk_en = 1; per_chk_en = 1;
    wait_passes(2);
    check_maps("initial");

    pats_p[0] = 32'hFFFF_FFFF; pats_l[0] = 32'h0000_0000;
    pats_p[1] = 32'hFFFF_FFFF; pats_l[1] = 32'hFFFF_FFFF;
    pats_p[2] = 32'h0000_0000; pats_l[2] = 32'hFFFF_FFFF;
    pats_p[3] = 32'h1234_5678; pats_l[3] = 32'h8765_4321;
    for (int k = 0; k < 4; k++) begin
      present = pats_p[k]; linkup = pats_l[k];
      wait_passes(2);
      check_maps("sweep");
      if (exp_evt) clear_evt();
    end

    // gating and stickiness on the selected PHY (address 5 present in pattern 3)
    present[5] = 1'b1;
    irq_en = 1'b0;
    linkup[5] = ~linkup[5];
    wait_passes(2);
    check_maps("irq off");
    chk(irq == 1'b0, "R9 gated irq", 32'(irq), 0);
    @(negedge clk) irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq enabled", 32'(irq), 1);
    linkup[5] = ~linkup[5];
    wait_passes(2);
    check_maps("toggle back");
    chk(link_evt == 1'b1, "R8 sticky", 32'(link_evt), 1);
    clear_evt();
    wait_passes(2);
    check_maps("no change");

    // select an absent PHY while the held link is up
    linkup[5] = 1'b1;
    wait_passes(2);
    check_maps("link up");
    clear_evt();
    present[9] = 1'b0;
    sel_phy = 5'd9;
    wait_passes(2);
    check_maps("absent select");
    chk(sel_link == 1'b0, "R7 absent selected", 32'(sel_link), 0);
    clear_evt();

    // idle gap of zero, then a longer one
    gap_chk_en = 0; gap_len = 8'd0;
    wait_passes(1);
    gap_chk_en = 1;
    wait_passes(2);
    gap_chk_en = 0; gap_len = 8'd7;
    wait_passes(1);
    gap_chk_en = 1;
    wait_passes(1);

    // slower management clock
    per_chk_en = 0; mdc_div = 8'd2;
    wait_passes(1);
    last_rise = 0; per_chk_en = 1;
    wait_passes(1);
    check_maps("slow clock");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule